// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic, and lets them be loaded and read back over the same data buses that normally carry FIFO words. An active-low configuration select, `cfg_sel_n`, turns the ordinary write and read strobes into register accesses. While it is low, each accepted write on the write clock stores the low offset bits of the input word into one of the two offset registers. A write pointer decides which register gets the word, and it flips after every stored word. On the read clock, each accepted read puts one offset on the output bus, zero-extended. A separate read pointer walks the two registers in the same order.

While `cfg_sel_n` is high, the strobes pass through to the FIFO storage as ordinary writes and reads. While it is low, they are blocked from reaching the storage. Words from the storage are captured into the output register on ordinary reads. The two offsets are driven out for use by the flag comparators, which sit outside this block.

Both data edges are plain strobes with no back-pressure. Every write cycle with `wr_en_n` low is accepted, and so is every read cycle with `rd_en_n` low. There is no ready signal. Any stalling for full or empty is the job of the storage side.

Top module: `ofs_cfg_port`

## Requirements
- R1: Each offset register is 14 bits wide and is loaded from `wr_data[13:0]`. Bits 17:14 of the input word have no effect on the stored value.
- R2: With `cfg_sel_n` low and `wr_en_n` low, successive write-clock edges load the empty offset, then the full offset, then the empty offset again, alternating without end.
- R3: When `wr_en_n` is high, no offset register and no write pointer changes, whatever the level of `cfg_sel_n`.
- R4: With `cfg_sel_n` high and `wr_en_n` low, `fifo_wr_o` is high and the offsets stay unchanged. `fifo_wr_o` is never high while `cfg_sel_n` is low.
- R5: Raising `cfg_sel_n` does not move either pointer. A load sequence may stop after one register, and a later load continues from the register that comes next.
- R6: With `cfg_sel_n` low and `rd_en_n` low, successive read-clock edges place the empty offset, then the full offset, then the empty offset again on `q_o`. The value appears from the edge on which the read is taken.
- R7: With `cfg_sel_n` high and `rd_en_n` low, `fifo_rd_o` is high and `q_o` captures `fifo_q` on the read-clock edge. `fifo_rd_o` is never high while `cfg_sel_n` is low.
- R8: A read-back offset reaches `q_o` with bits 17:14 at zero.
- R9: Reset (`rst_n` low) sets both offsets to 127, sets `q_o` to zero, and points both the write pointer and the read pointer at the empty-offset register.
- R10: When `rd_en_n` is high, `q_o` and the read pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| cfg_sel_n | input | 1 | Low: strobes reach the offset registers instead of the FIFO |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | 18 | Input word; low 14 bits feed the offsets |
| rd_en_n | input | 1 | Active-low read strobe |
| fifo_q | input | 18 | Word presented by the FIFO storage |
| fifo_wr_o | output | 1 | Ordinary write to the FIFO storage |
| fifo_rd_o | output | 1 | Ordinary read from the FIFO storage |
| q_o | output | 18 | Registered output word |
| ae_off_o | output | 14 | Current almost-empty offset |
| af_off_o | output | 14 | Current almost-full offset |

## Verification
Two things can coincide here: a register load on the write clock and a read-back on the read clock, in the same stretch of time, with each clock's pointer walking on its own. The bench runs the two clocks at the same rate with a phase offset, and mixes configuration and ordinary accesses on both sides. A scoreboard predicts every `q_o` word from a model of both pointers, so a read that takes the wrong register, or takes a FIFO word during configuration, shows up as a mismatch at the read edge. A reset issued with both pointers pointing at the full-offset register, followed by one load and one read-back, shows whether each pointer returned to the empty-offset register independently.

// File: rtl/ofs_cfg_pkg.sv
`timescale 1ns/1ps
package ofs_cfg_pkg;
  // Which offset register a pointer currently designates; order is behaviour.
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/ofs_wr_bank.sv
`timescale 1ns/1ps
module ofs_wr_bank
  import ofs_cfg_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int OFF_DEF = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [OFF_W-1:0] din,
  output logic [OFF_W-1:0] ae_q,
  output logic [OFF_W-1:0] af_q,
  output ofs_sel_e         ptr_q
);
  localparam logic [OFF_W-1:0] DEF_V = OFF_DEF[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q  <= DEF_V;
      af_q  <= DEF_V;
      ptr_q <= SEL_EMPTY;
    end else if (ld_stb) begin
      if (ptr_q == SEL_EMPTY) ae_q <= din;
      else                    af_q <= din;
      ptr_q <= (ptr_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end
endmodule

// File: rtl/ofs_rd_port.sv
`timescale 1ns/1ps
module ofs_rd_port
  import ofs_cfg_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFF_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic              fifo_stb,
  input  logic [OFF_W-1:0]  ae_i,
  input  logic [OFF_W-1:0]  af_i,
  input  logic [DATA_W-1:0] fifo_i,
  output logic [DATA_W-1:0] q_o,
  output ofs_sel_e          ptr_q
);
  logic [OFF_W-1:0]  pick;
  logic [DATA_W-1:0] pick_ext;

  assign pick = (ptr_q == SEL_EMPTY) ? ae_i : af_i;

  generate
    if (DATA_W > OFF_W) begin : g_pad
      assign pick_ext = {{(DATA_W-OFF_W){1'b0}}, pick};
    end else begin : g_trim
      assign pick_ext = pick[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o   <= '0;
      ptr_q <= SEL_EMPTY;
    end else if (cfg_stb) begin
      q_o   <= pick_ext;
      ptr_q <= (ptr_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end else if (fifo_stb) begin
      q_o <= fifo_i;
    end
  end
endmodule

// File: rtl/ofs_cfg_port.sv
`timescale 1ns/1ps
module ofs_cfg_port
  import ofs_cfg_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 14,
  parameter int OFF_DEF = 127
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_sel_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic [DATA_W-1:0] fifo_q,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o,
  output logic [DATA_W-1:0] q_o,
  output logic [OFF_W-1:0]  ae_off_o,
  output logic [OFF_W-1:0]  af_off_o
);
  logic     wr_cfg_stb;
  logic     rd_cfg_stb;
  ofs_sel_e wr_ptr;
  ofs_sel_e rd_ptr;

  // Strobe steering: configuration select diverts each strobe away from storage.
  assign wr_cfg_stb = !wr_en_n && !cfg_sel_n;
  assign rd_cfg_stb = !rd_en_n && !cfg_sel_n;
  assign fifo_wr_o  = !wr_en_n &&  cfg_sel_n;
  assign fifo_rd_o  = !rd_en_n &&  cfg_sel_n;

  ofs_wr_bank #(.OFF_W(OFF_W), .OFF_DEF(OFF_DEF)) u_wr (
    .clk    (wclk),
    .rst_n  (rst_n),
    .ld_stb (wr_cfg_stb),
    .din    (wr_data[OFF_W-1:0]),
    .ae_q   (ae_off_o),
    .af_q   (af_off_o),
    .ptr_q  (wr_ptr)
  );

  ofs_rd_port #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_rd (
    .clk      (rclk),
    .rst_n    (rst_n),
    .cfg_stb  (rd_cfg_stb),
    .fifo_stb (fifo_rd_o),
    .ae_i     (ae_off_o),
    .af_i     (af_off_o),
    .fifo_i   (fifo_q),
    .q_o      (q_o),
    .ptr_q    (rd_ptr)
  );
endmodule

// File: rtl/ofs_cfg_port_chk.sv
`timescale 1ns/1ps
module ofs_cfg_port_chk #(
  parameter int DATA_W = 18,
  parameter int OFF_W  = 14
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              cfg_sel_n,
  input logic              wr_en_n,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en_n,
  input logic              fifo_wr_o,
  input logic              fifo_rd_o,
  input logic [DATA_W-1:0] q_o,
  input logic [OFF_W-1:0]  ae_off_o,
  input logic [OFF_W-1:0]  af_off_o,
  input logic              wr_ptr,
  input logic              rd_ptr
);
  AST_AE_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && !cfg_sel_n && !wr_ptr) |=> (ae_off_o == $past(wr_data[OFF_W-1:0]) && $stable(af_off_o))); // R2
  AST_AF_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && !cfg_sel_n && wr_ptr) |=> (af_off_o == $past(wr_data[OFF_W-1:0]) && $stable(ae_off_o))); // R2
  AST_WPTR_FLIP: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && !cfg_sel_n) |=> (wr_ptr != $past(wr_ptr))); // R2
  AST_IDLE_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_en_n |=> ($stable(ae_off_o) && $stable(af_off_o) && $stable(wr_ptr))); // R3
  AST_NORMAL_WR_HOLD: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && cfg_sel_n) |=> ($stable(ae_off_o) && $stable(af_off_o) && $stable(wr_ptr))); // R4
  AST_NO_FIFO_WR: assert property (@(posedge wclk) disable iff (!rst_n)
    !cfg_sel_n |-> !fifo_wr_o); // R4
  AST_NO_FIFO_RD: assert property (@(posedge rclk) disable iff (!rst_n)
    !cfg_sel_n |-> !fifo_rd_o); // R7
  AST_RD_ZEXT: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en_n && !cfg_sel_n) |=> ((q_o >> OFF_W) == '0)); // R8
  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_en_n |=> ($stable(q_o) && $stable(rd_ptr))); // R10
endmodule

bind ofs_cfg_port ofs_cfg_port_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) chk_i (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n),
  .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
  .fifo_wr_o(fifo_wr_o), .fifo_rd_o(fifo_rd_o), .q_o(q_o),
  .ae_off_o(ae_off_o), .af_off_o(af_off_o),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/ofs_cfg_port_tb_top.sv
`timescale 1ns/1ps
module ofs_cfg_port_tb_top;
  localparam int DW = 18;
  localparam int OW = 14;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel_n = 1'b1;
  logic wr_en_n = 1'b1;
  logic rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] fifo_q = '0;
  logic fifo_wr_o, fifo_rd_o;
  logic [DW-1:0] q_o;
  logic [OW-1:0] ae_off_o, af_off_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [OW-1:0] m_ae, m_af;
  bit m_wptr, m_rptr;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_q;
  string tag_q[$];

  always #2.5 wclk = ~wclk;
  initial begin #1.5; forever #2.5 rclk = ~rclk; end

  ofs_cfg_port dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .fifo_q(fifo_q),
    .fifo_wr_o(fifo_wr_o), .fifo_rd_o(fifo_rd_o), .q_o(q_o),
    .ae_off_o(ae_off_o), .af_off_o(af_off_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ae = 14'd127; m_af = 14'd127; m_wptr = 0; m_rptr = 0;
  endtask

  // Write-side driver: one strobe cycle, model update, post-edge check.
  task automatic wr_cyc(input logic sel_n, input logic [DW-1:0] d, input string req);
    @(negedge wclk);
    cfg_sel_n = sel_n; wr_data = d; wr_en_n = 1'b0;
    #0.5 chk({req, " fifo_wr_o"}, DW'(fifo_wr_o), DW'(sel_n));
    if (!sel_n) begin
      if (!m_wptr) m_ae = d[OW-1:0]; else m_af = d[OW-1:0];
      m_wptr = ~m_wptr;
    end
    @(posedge wclk); #1;
    chk({req, " ae"}, DW'(ae_off_o), DW'(m_ae));
    chk({req, " af"}, DW'(af_off_o), DW'(m_af));
    @(negedge wclk); wr_en_n = 1'b1;
  endtask

  // Read-side driver: pushes the predicted word for the monitor.
  task automatic rd_cyc(input logic sel_n, input logic [DW-1:0] fd, input string req);
    @(negedge rclk);
    if (sel_n) exp_q.push_back(fd);
    else begin
      exp_q.push_back({{(DW-OW){1'b0}}, (m_rptr ? m_af : m_ae)});
      m_rptr = ~m_rptr;
    end
    tag_q.push_back(req);
    cfg_sel_n = sel_n; fifo_q = fd; rd_en_n = 1'b0;
    #0.5 chk({req, " fifo_rd_o"}, DW'(fifo_rd_o), DW'(sel_n));
    @(negedge rclk); rd_en_n = 1'b1;
  endtask

  // Monitor: compares q_o just after each accepted read edge.
  always @(posedge rclk) begin
    if (rst_n && !rd_en_n) begin
      logic [DW-1:0] e;
      string t;
      bit cfg;
      cfg = !cfg_sel_n;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #1;
      chk(t, q_o, e);
      if (cfg) chk("R8 upper bits", DW'(q_o >> OW), '0);
      last_q = q_o;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge wclk);
    #1;
    chk("R9 reset ae", DW'(ae_off_o), DW'(14'd127));
    chk("R9 reset af", DW'(af_off_o), DW'(14'd127));
    chk("R9 reset q", q_o, '0);
    @(negedge wclk); rst_n = 1'b1;
    repeat (2) @(negedge wclk);

    wr_cyc(1'b0, 18'h3C005, "R1 upper bits dropped");
    wr_cyc(1'b0, 18'h01234, "R2 second goes to full");
    wr_cyc(1'b0, 18'h00ABC, "R2 third back to empty");

    // R3: strobe inactive, select at both levels, data toggling.
    @(negedge wclk); cfg_sel_n = 1'b0; wr_data = 18'h1FFFF;
    repeat (3) @(negedge wclk);
    cfg_sel_n = 1'b1; wr_data = 18'h02222;
    repeat (3) @(negedge wclk);
    chk("R3 ae held", DW'(ae_off_o), DW'(m_ae));
    chk("R3 af held", DW'(af_off_o), DW'(m_af));

    wr_cyc(1'b1, 18'h3FFFF, "R4 normal write");
    wr_cyc(1'b0, 18'h00777, "R5 pointer kept across select");

    rd_cyc(1'b0, 18'h11111, "R6 readback empty");
    rd_cyc(1'b0, 18'h22222, "R6 readback full");
    rd_cyc(1'b1, 18'h2AAAA, "R7 normal read");
    rd_cyc(1'b0, 18'h33333, "R6 readback empty again");
    repeat (4) @(negedge rclk);
    chk("R10 q held", q_o, last_q);

    wr_cyc(1'b0, 18'h00100, "R2 empty reload");
    // Both pointers now at the full register; reset must bring them back.
    @(negedge wclk); rst_n = 1'b0; model_reset();
    #1;
    chk("R9 mid reset ae", DW'(ae_off_o), DW'(14'd127));
    chk("R9 mid reset q", q_o, '0);
    @(negedge wclk); rst_n = 1'b1;
    repeat (2) @(negedge wclk);
    wr_cyc(1'b0, 18'h00042, "R9 write pointer to empty");
    rd_cyc(1'b0, 18'h0, "R9 read pointer to empty");
    rd_cyc(1'b0, 18'h0, "R6 default full readback");
    repeat (4) @(negedge rclk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule